// File: doc/BRIEF.md
# Serial DMA Request Receiver and Grant Encoder

This block is the host end of a one-wire DMA request link. A single expansion agent reports all of its pending DMA channels as a short serial frame on an active-low request line. The block decodes each frame into an eight-bit pending set, and a new frame overwrites the old set completely. A fixed-priority arbiter picks one pending channel. The block sends that channel's number back on an active-low grant line and holds the grant until the DMA engine signals that the transfer has finished.

A frame starts when the request line falls from high to low. The eight clocks that follow carry one slot per channel, from channel 0 to channel 7. The DMA engine reads the decoded pending set and the granted channel number from the outputs. It ends a grant by pulsing `xfer_done`. The granted channel leaves the pending set when its grant starts. It is offered again only if a later frame reports it.

Top module: `dma_serial_host`

## Requirements
- R1: After reset, `gnt_n` is 1, `grant_active` is 0 and `pending` is 0.
- R2: A frame begins on the first clock at which `req_n` is sampled low after being sampled high while no frame is being received. The next eight clocks are slots for channels 0 through 7 in that order. A high level in a slot means the channel is requesting. `pending` shows the frame one clock after the last slot is sampled.
- R3: The slot for channel 4 is reserved. `pending[4]` is always 0.
- R4: Each completed frame replaces `pending` entirely. Earlier requests do not survive, even while a grant is held.
- R5: Channel 0 has the highest priority and channel 7 the lowest. Only pending channels are considered.
- R6: A grant is sent as follows: `gnt_n` is low for one clock as a start marker, then carries bits 0, 1 and 2 of the channel number on three clocks (the line level equals the bit), then stays low. For example, channel 6 is sent as 0,1,1 and channel 1 as 1,0,0.
- R7: `gnt_n` stays low and `grant_active` stays 1 until `xfer_done` is sampled high during the held phase. On the next clock `gnt_n` is 1 and `grant_active` is 0.
- R8: When a grant starts, the granted channel is cleared from `pending`. `grant_ch` then holds its number for the whole grant.
- R9: When no grant is active and `pending` is nonzero, the grant begins on the next clock. When `pending` is 0, no grant begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 1 | Serial request line from the expansion agent |
| xfer_done | input | 1 | Pulse from the DMA engine that ends the current grant |
| gnt_n | output | 1 | Serial grant line to the expansion agent |
| pending | output | 8 | Decoded set of pending channels |
| grant_active | output | 1 | A grant is in progress |
| grant_ch | output | 3 | Number of the granted channel |

## Verification
The hardest case to reach is a frame that arrives while a grant is held. The stored set must then be replaced and must not be merged with the old one, and the next grant must come only from the new set. The bench reaches this case by sending a frame that yields a grant and then holding off `xfer_done`. It sends two more frames back to back, with different channels, before releasing the transfer. It then checks the pending set and the channel granted next against the last frame only.

// File: rtl/dma_serial_host.sv
module dma_serial_host #(
  parameter int CH = 8,
  parameter logic [CH-1:0] RESERVED = 8'h10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_n,
  input  logic                  xfer_done,
  output logic                  gnt_n,
  output logic [CH-1:0]         pending,
  output logic                  grant_active,
  output logic [$clog2(CH)-1:0] grant_ch
);
  localparam int CW = $clog2(CH);

  typedef enum logic [1:0] {IDLE, MARK, SEND, HOLD} gstate_t;

  gstate_t state;
  logic          req_q, rx_on;
  logic [CW-1:0] rx_idx, bit_idx, pick;
  logic [CH-1:0] rx_sh;

  wire frame_start = !rx_on && req_q && !req_n;
  wire frame_end   = rx_on && (rx_idx == CW'(CH-1));
  wire [CH-1:0] frame_bits = {req_n, rx_sh[CH-1:1]};
  wire holding  = (state == HOLD);
  wire grant_go = (state == IDLE) && (|pending) && !frame_end;

  always_comb begin
    pick = '0;
    for (int i = CH-1; i >= 0; i--)
      if (pending[i]) pick = CW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b1;
      rx_on  <= 1'b0;
      rx_idx <= '0;
      rx_sh  <= '0;
    end else begin
      req_q <= req_n;
      if (frame_start) begin
        rx_on  <= 1'b1;
        rx_idx <= '0;
      end else if (rx_on) begin
        rx_sh  <= frame_bits;
        rx_idx <= rx_idx + 1'b1;
        if (frame_end) rx_on <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pending <= '0;
    else if (frame_end)
      pending <= frame_bits & ~RESERVED;
    else if (grant_go)
      pending[pick] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      grant_ch <= '0;
      bit_idx  <= '0;
    end else begin
      case (state)
        IDLE: if (grant_go) begin
          grant_ch <= pick;
          state    <= MARK;
        end
        MARK: begin
          bit_idx <= '0;
          state   <= SEND;
        end
        SEND: begin
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == CW'(CW-1)) state <= HOLD;
        end
        HOLD: if (xfer_done) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign grant_active = (state != IDLE);
  assign gnt_n = (state == IDLE) ? 1'b1 :
                 (state == SEND) ? grant_ch[bit_idx] : 1'b0;
endmodule

// File: rtl/dma_serial_host_chk.sv
module dma_serial_host_chk #(
  parameter int CH = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  xfer_done,
  input logic                  gnt_n,
  input logic [CH-1:0]         pending,
  input logic                  grant_active,
  input logic [$clog2(CH)-1:0] grant_ch,
  input logic                  in_hold
);
  assert_ch4_never_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pending[4]);

  assert_marker_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_active) |-> !gnt_n);

  assert_release_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && xfer_done) |=> (gnt_n && !grant_active));

  assert_hold_without_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !xfer_done) |=> (!gnt_n && grant_active));

  assert_granted_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_active) |-> !pending[grant_ch]);

  assert_highest_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_active) |-> (($past(pending) & ((8'd1 << grant_ch) - 8'd1)) == 8'd0));

  assert_no_grant_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_active && pending == '0) |=> !grant_active);
endmodule

bind dma_serial_host dma_serial_host_chk #(.CH(CH)) chk (
  .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .gnt_n(gnt_n),
  .pending(pending), .grant_active(grant_active), .grant_ch(grant_ch),
  .in_hold(holding)
);

// File: tb/dma_serial_host_test.sv
`timescale 1ns/1ps
module dma_serial_host_test;
  logic clk = 0, rst_n = 0, req_n = 1, xfer_done = 0;
  logic gnt_n, grant_active;
  logic [7:0] pending;
  logic [2:0] grant_ch;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_serial_host uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .xfer_done(xfer_done),
    .gnt_n(gnt_n), .pending(pending), .grant_active(grant_active), .grant_ch(grant_ch)
  );

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(logic [7:0] bits);
    @(negedge clk) req_n = 1;
    @(negedge clk) req_n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) req_n = bits[i];
    end
    @(negedge clk) req_n = 1;
  endtask

  task automatic expect_grant(string tag, logic [2:0] ch, logic [7:0] pend_after);
    int n = 0;
    while (!grant_active && n < 20) begin
      @(negedge clk); n++;
    end
    chk({tag, " R9 grant start"}, grant_active, 1);
    chk({tag, " R6 marker"}, gnt_n, 0);
    chk({tag, " R5 channel"}, grant_ch, ch);
    chk({tag, " R8 pending cleared"}, pending, pend_after);
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      chk({tag, " R6 code bit"}, gnt_n, ch[b]);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk({tag, " R7 held low"}, gnt_n, 0);
    end
  endtask

  task automatic finish_xfer(string tag);
    xfer_done = 1;
    @(negedge clk) xfer_done = 0;
    chk({tag, " R7 released"}, gnt_n, 1);
    chk({tag, " R7 inactive"}, grant_active, 0);
  endtask

  task automatic t_reset;
    chk("R1 gnt_n", gnt_n, 1);
    chk("R1 grant_active", grant_active, 0);
    chk("R1 pending", pending, 0);
  endtask

  task automatic t_basic;
    send_frame(8'h22);
    chk("R2 pending decoded", pending, 8'h22);
    chk("R9 not yet granted", grant_active, 0);
    @(negedge clk);
    chk("R9 grant next clock", grant_active, 1);
    expect_grant("basic ch1", 3'd1, 8'h20);
    finish_xfer("basic ch1");
    expect_grant("basic ch5", 3'd5, 8'h00);
    finish_xfer("basic ch5");
  endtask

  task automatic t_reserved;
    send_frame(8'h10);
    chk("R3 ch4 ignored", pending, 8'h00);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R3 R9 no grant", grant_active, 0);
      chk("R3 gnt_n idle", gnt_n, 1);
    end
    send_frame(8'hB0);
    chk("R3 ch4 masked", pending, 8'hA0);
    expect_grant("reserved ch5", 3'd5, 8'h80);
    finish_xfer("reserved ch5");
    expect_grant("reserved ch7", 3'd7, 8'h00);
    finish_xfer("reserved ch7");
  endtask

  task automatic t_replace;
    send_frame(8'h22);
    expect_grant("replace ch1", 3'd1, 8'h20);
    send_frame(8'h81);
    chk("R4 first replacement", pending, 8'h81);
    send_frame(8'h04);
    chk("R4 second replacement", pending, 8'h04);
    chk("R4 grant still held", gnt_n, 0);
    finish_xfer("replace ch1");
    expect_grant("replace ch2", 3'd2, 8'h00);
    finish_xfer("replace ch2");
  endtask

  task automatic t_priority;
    send_frame(8'hFF);
    chk("R2 R3 all slots", pending, 8'hEF);
    expect_grant("prio ch0", 3'd0, 8'hEE);
    finish_xfer("prio ch0");
    expect_grant("prio ch1", 3'd1, 8'hEC);
    finish_xfer("prio ch1");
    expect_grant("prio ch2", 3'd2, 8'hE8);
    finish_xfer("prio ch2");
    expect_grant("prio ch3", 3'd3, 8'hE0);
    finish_xfer("prio ch3");
    expect_grant("prio ch5 skips 4", 3'd5, 8'hC0);
    send_frame(8'h00);
    chk("R4 cleared by empty frame", pending, 8'h00);
    finish_xfer("prio ch5");
    @(negedge clk);
    chk("R9 idle after empty frame", grant_active, 0);
  endtask

  task automatic t_code6;
    send_frame(8'h40);
    expect_grant("code ch6", 3'd6, 8'h00);
    finish_xfer("code ch6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_reserved();
    t_replace();
    t_priority();
    t_code6();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule